// File: doc/BRIEF.md
# Audio Master Clock Divider Chain

This block produces the three timing references of a serial audio port running as clock master: a root (oversampling) clock, a bit clock and a frame (left/right) clock. All three are derived from one source clock. A prescaler first divides the source clock down to the root rate and emits a one-cycle root tick per root period. A first toggle stage turns root ticks into the bit clock, and a second toggle stage, advanced only on bit-clock falling events, turns those into the frame clock. The three outputs therefore stay phase locked to each other.

The frame ratio of the root clock and of the bit clock each come from a 2-bit code with an irregular value order. Either ratio can be left to automatic selection, which picks it from the sample width. The configuration is resolved and checked as it is presented. It is latched on the cycle the port is enabled, and all counters restart together on that cycle. Two kinds of combination are rejected and keep the outputs idle: a 24-bit sample with a 256 or 512 root ratio, and a pair of ratios whose quotient is not an integer. A ratio request that differs from the latched one while the port runs is refused and flagged. In slave mode the block drives nothing and ignores its settings.

Top module: `acd_clock_chain`

## Requirements
- R1: Root ratio code root_code maps 0 to 256, 1 to 512, 2 to 384 and 3 to 768 frame periods. With a legal setting, the first frame-clock rise comes rfs*P/2 cycles after the start cycle, where P is the prescale factor.
- R2: Bit ratio code bit_code maps 0 to 32, 1 to 48, 2 to 16 and 3 to 24. The bit clock toggles every rfs*P/(2*bfs) cycles, starting low, and rises only after a cycle that carried a root tick.
- R3: root_tick pulses once every pre_val+1 cycles when pre_en is 1, and on every cycle when pre_en is 0.
- R4: Width code width_code 2 (24-bit) with an effective root ratio of 256 or 512 raises cfg_err. An enable then produces no root ticks and no clock edges.
- R5: An effective root ratio that is not an integer multiple of the effective bit ratio (256 or 512 with 24 or 48) raises cfg_err and keeps the outputs idle.
- R6: When bit_auto is 1, the bit ratio is twice the sample width. Width codes: 1 is 8 bits, 2 is 24 bits, 0 and 3 are 16 bits.
- R7: When root_auto is 1, the root ratio is 256 if the effective bit ratio is 16 or 32, and 384 otherwise.
- R8: While slave_sel is 1, root_tick, bclk and lrclk stay 0 and cfg_err stays 0, whatever the other settings are.
- R9: If the effective ratios differ from the latched ones while running, cfg_refused is 1 in the same cycle, and the running periods keep their latched values.
- R10: The frame clock changes only in a cycle where the bit clock falls, except when the port stops.
- R11: One cycle after port_enable goes low, root_tick, bclk and lrclk are all 0.
- R12: During and after reset, root_tick, bclk, lrclk and cfg_refused are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_enable | input | 1 | Run request; a rising edge latches the configuration and restarts the counters |
| slave_sel | input | 1 | 1 selects slave mode; outputs are held idle |
| pre_en | input | 1 | Prescaler enable |
| pre_val | input | PRE_W | Prescale divide value minus one |
| root_code | input | 2 | Root-to-frame ratio code |
| bit_code | input | 2 | Bit-to-frame ratio code |
| root_auto | input | 1 | Pick the root ratio automatically |
| bit_auto | input | 1 | Pick the bit ratio automatically |
| width_code | input | 2 | Sample width code |
| root_tick | output | 1 | One-cycle enable per root clock period |
| bclk | output | 1 | Bit clock level |
| lrclk | output | 1 | Frame clock level |
| cfg_err | output | 1 | Requested combination is illegal |
| cfg_refused | output | 1 | Requested ratios differ from the latched ones while running |

## Verification
A wrong decode or a wrong latched divisor shows up at the first bit-clock edge, which then lands at a cycle index other than rfs*P/(2*bfs) after the start cycle. A wrong frame-stage count shows up at the first frame-clock rise, within one frame. A stage that is not cleared on stop, or a start that ignores an illegal combination, leaves a toggling output or a root tick visible one cycle after the condition. Because of that, every configuration is swept from a fresh start, and each run measures the edge cycle indices directly.

// File: rtl/acd_pkg.sv
package acd_pkg;

   localparam int RATIO_W = 10;
   localparam int BRAT_W  = 6;
   localparam int WID_W   = 5;

   typedef logic [RATIO_W-1:0] ratio_t;
   typedef logic [BRAT_W-1:0]  brat_t;
   typedef logic [WID_W-1:0]   width_t;

   // root ratio code: irregular ordering 256,512,384,768
   function automatic ratio_t root_of(input logic [1:0] c);
      case (c)
         2'd1:    return ratio_t'(512);
         2'd2:    return ratio_t'(384);
         2'd3:    return ratio_t'(768);
         default: return ratio_t'(256);
      endcase
   endfunction

   // bit ratio code: 32,48,16,24
   function automatic brat_t bits_of(input logic [1:0] c);
      case (c)
         2'd1:    return brat_t'(48);
         2'd2:    return brat_t'(16);
         2'd3:    return brat_t'(24);
         default: return brat_t'(32);
      endcase
   endfunction

   function automatic width_t width_of(input logic [1:0] c);
      case (c)
         2'd1:    return width_t'(8);
         2'd2:    return width_t'(24);
         default: return width_t'(16);
      endcase
   endfunction

   // half of root/bit quotient; zero marks a non-integer quotient
   function automatic brat_t half_div(input ratio_t r, input brat_t b);
      brat_t h;
      h = '0;
      case (b)
         brat_t'(16): case (r)
            ratio_t'(256): h = brat_t'(8);
            ratio_t'(512): h = brat_t'(16);
            ratio_t'(384): h = brat_t'(12);
            ratio_t'(768): h = brat_t'(24);
            default:       h = '0;
         endcase
         brat_t'(32): case (r)
            ratio_t'(256): h = brat_t'(4);
            ratio_t'(512): h = brat_t'(8);
            ratio_t'(384): h = brat_t'(6);
            ratio_t'(768): h = brat_t'(12);
            default:       h = '0;
         endcase
         brat_t'(24): case (r)
            ratio_t'(384): h = brat_t'(8);
            ratio_t'(768): h = brat_t'(16);
            default:       h = '0;
         endcase
         brat_t'(48): case (r)
            ratio_t'(384): h = brat_t'(4);
            ratio_t'(768): h = brat_t'(8);
            default:       h = '0;
         endcase
         default: h = '0;
      endcase
      return h;
   endfunction

endpackage

// File: rtl/acd_ratio_resolve.sv
module acd_ratio_resolve
   import acd_pkg::*;
(
   input  logic [1:0] root_code,
   input  logic [1:0] bit_code,
   input  logic       root_auto,
   input  logic       bit_auto,
   input  logic [1:0] width_code,
   output ratio_t     rfs,
   output brat_t      bfs,
   output brat_t      half_bit,
   output logic       bad_width,
   output logic       bad_div
);

   width_t wbits;

   always_comb begin
      wbits = width_of(width_code);
      if (bit_auto) bfs = {wbits, 1'b0};
      else          bfs = bits_of(bit_code);

      if (root_auto) begin
         if (bfs == brat_t'(16) || bfs == brat_t'(32)) rfs = ratio_t'(256);
         else                                          rfs = ratio_t'(384);
      end else begin
         rfs = root_of(root_code);
      end

      half_bit  = half_div(rfs, bfs);
      bad_div   = (half_bit == '0);
      bad_width = (wbits == width_t'(24)) &&
                  (rfs == ratio_t'(256) || rfs == ratio_t'(512));
   end

endmodule

// File: rtl/acd_prescaler.sv
module acd_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [PRE_W-1:0] div_m1,
   output logic             tick
);

   logic [PRE_W-1:0] cnt;

   assign tick = run && (cnt == div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (tick)    cnt <= '0;
      else if (run)     cnt <= cnt + PRE_W'(1);
   end

endmodule

// File: rtl/acd_toggle_div.sv
module acd_toggle_div #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick_in,
   input  logic [CNT_W-1:0] half,
   output logic             lvl,
   output logic             fall
);

   logic [CNT_W-1:0] cnt;
   logic             wrap;

   assign wrap = tick_in && (cnt == half - CNT_W'(1));
   assign fall = wrap && lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         lvl <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         lvl <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         lvl <= ~lvl;
      end else if (tick_in) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/acd_clock_chain.sv
module acd_clock_chain
   import acd_pkg::*;
#(
   parameter int PRE_W = 8,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port_enable,
   input  logic             slave_sel,
   input  logic             pre_en,
   input  logic [PRE_W-1:0] pre_val,
   input  logic [1:0]       root_code,
   input  logic [1:0]       bit_code,
   input  logic             root_auto,
   input  logic             bit_auto,
   input  logic [1:0]       width_code,
   output logic             root_tick,
   output logic             bclk,
   output logic             lrclk,
   output logic             cfg_err,
   output logic             cfg_refused
);

   localparam int N_STAGE = 2;

   if (CNT_W < BRAT_W) begin : g_cnt_too_narrow
      $error("CNT_W must hold the largest half divisor");
   end
   if (PRE_W < 1) begin : g_pre_too_narrow
      $error("PRE_W must be at least 1");
   end

   ratio_t rfs_req, rfs_cap;
   brat_t  bfs_req, bfs_cap;
   brat_t  half_req, half_cap;
   logic   bad_width, bad_div, illegal;
   logic   [PRE_W-1:0] pre_cap;
   logic   en_q, run, stop, start, clr, run_eff;

   acd_ratio_resolve u_resolve (
      .root_code (root_code),
      .bit_code  (bit_code),
      .root_auto (root_auto),
      .bit_auto  (bit_auto),
      .width_code(width_code),
      .rfs       (rfs_req),
      .bfs       (bfs_req),
      .half_bit  (half_req),
      .bad_width (bad_width),
      .bad_div   (bad_div)
   );

   assign illegal = bad_width || bad_div;
   assign stop    = !port_enable || slave_sel;
   assign start   = !stop && !en_q;
   assign clr     = start || stop || !run;
   assign run_eff = run && !stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         run      <= 1'b0;
         rfs_cap  <= '0;
         bfs_cap  <= '0;
         half_cap <= '0;
         pre_cap  <= '0;
      end else begin
         en_q <= !stop;
         if (stop) begin
            run <= 1'b0;
         end else if (start) begin
            run      <= !illegal;
            rfs_cap  <= rfs_req;
            bfs_cap  <= bfs_req;
            half_cap <= half_req;
            pre_cap  <= pre_en ? pre_val : '0;
         end
      end
   end

   acd_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .run   (run_eff),
      .div_m1(pre_cap),
      .tick  (root_tick)
   );

   logic [CNT_W-1:0] half_arr [N_STAGE];
   logic             tick_chain [N_STAGE+1];
   logic             lvl_arr [N_STAGE];

   assign half_arr[0]   = CNT_W'(half_cap);
   assign half_arr[1]   = CNT_W'(bfs_cap[BRAT_W-1:1]);
   assign tick_chain[0] = root_tick;

   for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
      acd_toggle_div #(.CNT_W(CNT_W)) u_div (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr),
         .tick_in(tick_chain[s]),
         .half   (half_arr[s]),
         .lvl    (lvl_arr[s]),
         .fall   (tick_chain[s+1])
      );
   end

   assign bclk        = lvl_arr[0];
   assign lrclk       = lvl_arr[1];
   assign cfg_err     = !slave_sel && illegal;
   assign cfg_refused = run_eff && ((rfs_req != rfs_cap) || (bfs_req != bfs_cap));

endmodule

// File: rtl/acd_chain_chk.sv
module acd_chain_chk (
   input logic clk,
   input logic rst_n,
   input logic port_enable,
   input logic slave_sel,
   input logic cfg_err,
   input logic root_tick,
   input logic bclk,
   input logic lrclk
);

   p_slave_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      slave_sel |=> (!root_tick && !bclk && !lrclk));

   p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !port_enable |=> (!root_tick && !bclk && !lrclk));

   p_illegal_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(port_enable) && cfg_err && !slave_sel) |=> (!root_tick && !bclk && !lrclk));

   p_bclk_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bclk) |-> $past(root_tick));

   p_frame_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((lrclk != $past(lrclk)) && $past(port_enable && !slave_sel)) |->
      ($past(bclk) && !bclk));

endmodule

bind acd_clock_chain acd_chain_chk u_chk (.*);

// File: tb/sim_acd_clock_chain.sv
module sim_acd_clock_chain;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_enable = 1'b0, slave_sel = 1'b0, pre_en = 1'b0;
   logic [7:0] pre_val = '0;
   logic [1:0] root_code = '0, bit_code = '0, width_code = '0;
   logic       root_auto = 1'b0, bit_auto = 1'b0;
   logic       root_tick, bclk, lrclk, cfg_err, cfg_refused;

   int n_chk = 0;
   int n_fail = 0;

   acd_clock_chain u0 (
      .clk(clk), .rst_n(rst_n), .port_enable(port_enable), .slave_sel(slave_sel),
      .pre_en(pre_en), .pre_val(pre_val), .root_code(root_code), .bit_code(bit_code),
      .root_auto(root_auto), .bit_auto(bit_auto), .width_code(width_code),
      .root_tick(root_tick), .bclk(bclk), .lrclk(lrclk), .cfg_err(cfg_err),
      .cfg_refused(cfg_refused)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // observe n sampled cycles after the start edge; optionally change root_code
   task automatic observe(input int n, input int chg_at,
                          output int fb, output int sb, output int fl,
                          output int ticks, output int btog, output int ltog,
                          output int refused_after, output int err0);
      int pb, pl;
      pb = 0; pl = 0; fb = -1; sb = -1; fl = -1;
      ticks = 0; btog = 0; ltog = 0; refused_after = 0; err0 = 0;
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         if (j == 0) err0 = cfg_err;
         if (j == chg_at + 1) refused_after = cfg_refused;
         if (root_tick) ticks++;
         if (bclk != pb) begin
            btog++;
            if (fb < 0) fb = j; else if (sb < 0) sb = j;
         end
         if (lrclk != pl) begin
            ltog++;
            if (fl < 0) fl = j;
         end
         pb = bclk; pl = lrclk;
         if (j == chg_at) root_code = 2'd3;
      end
   endtask

   task automatic stop_and_check();
      port_enable = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(!bclk && !lrclk && !root_tick, "R11 idle after stop",
          int'({root_tick, bclk, lrclk}), 0);
      @(negedge clk);
   endtask

   task automatic run_case(input int rc, input int bc, input int wc,
                           input bit ra, input bit ba, input bit pe, input int pv);
      int w, bfs_e, rfs_e, p, h, n, legal, badw;
      int fb, sb, fl, ticks, btog, ltog, rf, e0;
      string tr, tb;
      w = (wc == 1) ? 8 : (wc == 2) ? 24 : 16;
      if (ba) bfs_e = 2 * w;
      else    bfs_e = (bc == 0) ? 32 : (bc == 1) ? 48 : (bc == 2) ? 16 : 24;
      if (ra) rfs_e = (bfs_e == 16 || bfs_e == 32) ? 256 : 384;
      else    rfs_e = (rc == 0) ? 256 : (rc == 1) ? 512 : (rc == 2) ? 384 : 768;
      p = pe ? pv + 1 : 1;
      badw  = (w == 24 && (rfs_e == 256 || rfs_e == 512));
      legal = !badw && (rfs_e % bfs_e == 0);
      tr = ra ? "R7" : "R1";
      tb = ba ? "R6" : "R2";

      @(negedge clk);
      root_code = rc[1:0]; bit_code = bc[1:0]; width_code = wc[1:0];
      root_auto = ra; bit_auto = ba; pre_en = pe; pre_val = pv[7:0];
      port_enable = 1'b1;
      @(posedge clk);
      if (legal) begin
         h = rfs_e / bfs_e / 2;
         n = rfs_e * p / 2 + 2;
         observe(n, -1, fb, sb, fl, ticks, btog, ltog, rf, e0);
         chk(e0 == 0, "R5 legal combo has no error", e0, 0);
         chk(fb == h * p, {tb, " first bit edge"}, fb, h * p);
         chk(sb == 2 * h * p, {tb, " second bit edge"}, sb, 2 * h * p);
         chk(fl == rfs_e * p / 2, {tr, " R10 first frame edge"}, fl, rfs_e * p / 2);
         chk(ticks == n / p, "R3 root tick count", ticks, n / p);
         chk(btog == (n - 1) / (h * p), {tb, " bit toggle count"}, btog, (n - 1) / (h * p));
      end else begin
         observe(40, -1, fb, sb, fl, ticks, btog, ltog, rf, e0);
         chk(e0 == 1, badw ? "R4 width error flag" : "R5 divisor error flag", e0, 1);
         chk(ticks + btog + ltog == 0, badw ? "R4 outputs idle" : "R5 outputs idle",
             ticks + btog + ltog, 0);
      end
      stop_and_check();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int fb, sb, fl, ticks, btog, ltog, rf, e0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!root_tick && !bclk && !lrclk && !cfg_refused, "R12 reset state",
          int'({root_tick, bclk, lrclk, cfg_refused}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!root_tick && !bclk && !lrclk, "R12 idle after reset",
          int'({root_tick, bclk, lrclk}), 0);

      // sweep all codes and auto selections, prescaler off
      for (int wc = 0; wc < 3; wc++)
         for (int bs = 0; bs < 5; bs++)
            for (int rs = 0; rs < 5; rs++)
               run_case(rs & 3, bs & 3, wc, rs == 4, bs == 4, 1'b0, 0);

      // prescaler factors
      run_case(0, 0, 0, 1'b0, 1'b0, 1'b1, 0);
      run_case(0, 0, 0, 1'b0, 1'b0, 1'b1, 2);
      run_case(0, 2, 1, 1'b0, 1'b0, 1'b1, 4);
      run_case(2, 1, 2, 1'b0, 1'b0, 1'b1, 1);
      run_case(0, 0, 0, 1'b0, 1'b0, 1'b0, 5);   // R3: value ignored when disabled

      // slave mode with an illegal request
      @(negedge clk);
      root_code = 2'd0; bit_code = 2'd1; width_code = 2'd2;
      root_auto = 1'b0; bit_auto = 1'b0; pre_en = 1'b0;
      slave_sel = 1'b1; port_enable = 1'b1;
      @(posedge clk);
      observe(60, -1, fb, sb, fl, ticks, btog, ltog, rf, e0);
      chk(e0 == 0 && cfg_err == 0, "R8 no error in slave", int'(cfg_err), 0);
      chk(ticks + btog + ltog == 0, "R8 outputs idle in slave", ticks + btog + ltog, 0);
      slave_sel = 1'b0;
      stop_and_check();

      // ratio change while running is refused
      @(negedge clk);
      root_code = 2'd0; bit_code = 2'd0; width_code = 2'd0;
      port_enable = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(cfg_refused == 1'b0, "R9 no refusal when unchanged", int'(cfg_refused), 0);
      observe(129, 20, fb, sb, fl, ticks, btog, ltog, rf, e0);
      chk(rf == 1, "R9 refusal flagged", rf, 1);
      chk(fl == 127, "R9 frame period kept", fl, 127);
      chk(fb == 3, "R9 bit period kept", fb, 3);
      stop_and_check();
      root_code = 2'd0;
      @(negedge clk);
      chk(cfg_refused == 1'b0, "R9 no refusal when stopped", int'(cfg_refused), 0);

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule